// File: doc/BRIEF.md
# Disk Rotational Position Tracker

This block keeps track of where a head-per-track disk is in its rotation, counted as a word index on one track. A prescaler turns the system clock into word periods, and a free-running position counter advances once per period, wrapping at the end of the track. From that position the block produces three things. The first is a photocell-style index bit that is high for a short window right after the track origin. The second is a flag that is true while a requested word is under the heads. The third is the rotational wait, in clock cycles, until the requested word comes around.

A controller loads the word period through `period_i` during reset and drives the low bits of a disk address on `target_i`. It can read `wait_o` to schedule a transfer, or it can pulse `start_i` and wait for the one-cycle `ready_o` that marks the word under the heads.

Top module: `disk_rot_tracker`

## Requirements
- R1: While reset is asserted and after its release, until the first position advance, `pos_o` is 0, `pcell_o` is 1 and `ready_o` is 0.
- R2: The period is captured on the first clock edge after reset release. After that, `pos_o` increments by one every P clock edges, where P is the captured period, and wraps from 2047 to 0. After release, edge number n (counting from 0) leaves `pos_o` = floor(n/P) mod 2048.
- R3: `period_i` is sampled only on that first edge and must be non-zero there. Later changes of `period_i` have no effect on the advance rate.
- R4: `pcell_o` is 1 exactly when `pos_o` is below 6. It changes on the same edge as `pos_o`.
- R5: `match_o` is 1 exactly when `target_i` equals `pos_o`. It is combinational.
- R6: `wait_o` equals ((`target_i` − `pos_o`) mod 2048) × P. It is combinational.
- R7: `start_i` high at an edge arms the block with `target_i`. `ready_o` is then high for one cycle, after the first later advance edge that moves `pos_o` onto the target. If the target equals the current position, this takes a full revolution.
- R8: `start_i` while armed replaces the armed target, and only the new target produces `ready_o`. `ready_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | PER_W | Clocks per word, captured after reset |
| target_i | input | WORD_BITS | Requested word index on the track |
| start_i | input | 1 | Arm the start-ready watch on `target_i` |
| pos_o | output | WORD_BITS | Current word under the heads |
| pcell_o | output | 1 | Index window bit, high while position < 6 |
| match_o | output | 1 | Requested word is under the heads now |
| wait_o | output | WORD_BITS+PER_W | Clocks until the requested word arrives |
| ready_o | output | 1 | One-cycle pulse when the armed word arrives |

## Verification
The bench builds the block with its default widths: an 11-bit word index, so a 2048-word track, and a 16-bit period field. It reloads periods of 1 to 4 through repeated resets, which keeps a full revolution within a few thousand cycles. At a period of one, the free-running phase crosses the track wrap and the whole index window. The armed-start runs reach the full-revolution case, the track ends 0 and 2047, and a replaced target, all under several periods.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int unsigned DRT_WORD_BITS = 11;
  localparam int unsigned DRT_PER_W     = 16;
  localparam int unsigned DRT_PCELL_WIN = 6;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic [PER_W-1:0] per_o,
  output logic             tick_o
);
  logic             init_q, init_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last   = (cnt_q == per_q - PER_W'(1));
  assign tick_o = !init_q && last;
  assign per_o  = per_q;

  always_comb begin
    init_d = 1'b0;
    per_d  = per_q;
    cnt_d  = cnt_q;
    if (init_q) begin
      per_d = period_i;
      cnt_d = '0;
    end else if (last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      per_q  <= '0;
      cnt_q  <= '0;
    end else begin
      init_q <= init_d;
      per_q  <= per_d;
      cnt_q  <= cnt_d;
    end
  end

  // R3: a zero period is illegal when it is captured
  p_period_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> (period_i != '0));
  // R3: once captured, the period never changes
  p_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |=> $stable(per_q));
  // R2: the prescaler stays inside one period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |-> (cnt_q < per_q));
endmodule

// File: rtl/drt_position.sv
module drt_position #(
  parameter int unsigned WORD_BITS = 11,
  parameter int unsigned PCELL_WIN = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  output logic [WORD_BITS-1:0] pos_o,
  output logic [WORD_BITS-1:0] pos_next_o,
  output logic                 pcell_o
);
  localparam logic [WORD_BITS-1:0] WIN = WORD_BITS'(PCELL_WIN);

  logic [WORD_BITS-1:0] pos_q, pos_d;
  logic                 pcell_q, pcell_d;

  assign pos_next_o = pos_q + WORD_BITS'(1);
  assign pos_o      = pos_q;
  assign pcell_o    = pcell_q;

  always_comb begin
    pos_d   = pos_q;
    pcell_d = pcell_q;
    if (tick_i) begin
      pos_d   = pos_next_o;
      pcell_d = (pos_next_o < WIN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      pcell_q <= 1'b1;
    end else begin
      pos_q   <= pos_d;
      pcell_q <= pcell_d;
    end
  end

  // R2: one step per period tick, wrapping at the track end
  p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (pos_q == WORD_BITS'($past(pos_q) + WORD_BITS'(1))));
  p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pos_q));
  // R4: the index bit tracks the window every cycle
  p_pcell_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pcell_q == (pos_q < WIN));
endmodule

// File: rtl/drt_arrival.sv
module drt_arrival #(
  parameter int unsigned WORD_BITS = 11,
  parameter int unsigned PER_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_i,
  input  logic [WORD_BITS-1:0]       pos_i,
  input  logic [WORD_BITS-1:0]       pos_next_i,
  input  logic [PER_W-1:0]           per_i,
  input  logic [WORD_BITS-1:0]       target_i,
  input  logic                       start_i,
  output logic                       match_o,
  output logic [WORD_BITS+PER_W-1:0] wait_o,
  output logic                       ready_o
);
  localparam int unsigned WAIT_W = WORD_BITS + PER_W;

  logic [WORD_BITS-1:0] delta;
  logic                 armed_q, armed_d;
  logic [WORD_BITS-1:0] tgt_q, tgt_d;
  logic                 ready_q, ready_d;

  // modular distance: the subtraction wraps at the track length
  assign delta   = target_i - pos_i;
  assign wait_o  = WAIT_W'(delta) * WAIT_W'(per_i);
  assign match_o = (target_i == pos_i);
  assign ready_o = ready_q;

  always_comb begin
    armed_d = armed_q;
    tgt_d   = tgt_q;
    ready_d = 1'b0;
    if (start_i) begin
      armed_d = 1'b1;
      tgt_d   = target_i;
    end else if (armed_q && tick_i && (pos_next_i == tgt_q)) begin
      armed_d = 1'b0;
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tgt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      tgt_q   <= tgt_d;
      ready_q <= ready_d;
    end
  end

  // R7: the pulse only appears with the armed word under the heads
  p_ready_at_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> (pos_i == tgt_q));
  // R8: the pulse lasts a single cycle
  p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);
endmodule

// File: rtl/disk_rot_tracker.sv
module disk_rot_tracker
  import drt_pkg::*;
#(
  parameter int unsigned WORD_BITS = DRT_WORD_BITS,
  parameter int unsigned PER_W     = DRT_PER_W,
  parameter int unsigned PCELL_WIN = DRT_PCELL_WIN
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PER_W-1:0]           period_i,
  input  logic [WORD_BITS-1:0]       target_i,
  input  logic                       start_i,
  output logic [WORD_BITS-1:0]       pos_o,
  output logic                       pcell_o,
  output logic                       match_o,
  output logic [WORD_BITS+PER_W-1:0] wait_o,
  output logic                       ready_o
);
  logic [PER_W-1:0]     per;
  logic                 tick;
  logic [WORD_BITS-1:0] pos_next;

  drt_prescaler #(.PER_W(PER_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .per_o    (per),
    .tick_o   (tick)
  );

  drt_position #(.WORD_BITS(WORD_BITS), .PCELL_WIN(PCELL_WIN)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .pos_o      (pos_o),
    .pos_next_o (pos_next),
    .pcell_o    (pcell_o)
  );

  drt_arrival #(.WORD_BITS(WORD_BITS), .PER_W(PER_W)) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .pos_i      (pos_o),
    .pos_next_i (pos_next),
    .per_i      (per),
    .target_i   (target_i),
    .start_i    (start_i),
    .match_o    (match_o),
    .wait_o     (wait_o),
    .ready_o    (ready_o)
  );
endmodule

// File: tb/disk_rot_tracker_tb_top.sv
module disk_rot_tracker_tb_top;
  localparam int unsigned WB = 11;
  localparam int unsigned PW = 16;
  localparam int unsigned TW = 2048;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] period_i;
  logic [WB-1:0] target_i;
  logic          start_i;
  logic [WB-1:0] pos_o;
  logic          pcell_o, match_o, ready_o;
  logic [WB+PW-1:0] wait_o;

  always #10 clk = ~clk;

  disk_rot_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .target_i(target_i),
    .start_i(start_i), .pos_o(pos_o), .pcell_o(pcell_o), .match_o(match_o),
    .wait_o(wait_o), .ready_o(ready_o)
  );

  int unsigned cyc;
  int unsigned per_cur;
  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int unsigned exp_pos(input int unsigned c, input int unsigned p);
    if (c == 0) return 0;
    return ((c - 1) / p) % TW;
  endfunction

  function automatic longint exp_wait(input int unsigned tgt, input int unsigned pos,
                                      input int unsigned p);
    return longint'((tgt + TW - pos) % TW) * longint'(p);
  endfunction

  // first edge index after n_a at which the position lands on tgt
  function automatic int unsigned ready_edge(input int unsigned n_a, input int unsigned tgt,
                                             input int unsigned p);
    int unsigned k0, k;
    k0 = n_a / p + 1;
    k  = k0 + ((tgt + TW - (k0 % TW)) % TW);
    return k * p;
  endfunction

  task automatic check_now();
    int unsigned ep;
    ep = exp_pos(cyc, per_cur);
    chk(pos_o == WB'(ep), "R2 position", pos_o, ep);
    chk(pcell_o == (ep < 6), "R4 index window", pcell_o, (ep < 6));
    chk(match_o == (target_i == WB'(ep)), "R5 address match", match_o, (target_i == WB'(ep)));
    chk(longint'(wait_o) == exp_wait(target_i, ep, per_cur), "R6 wait",
        wait_o, exp_wait(target_i, ep, per_cur));
  endtask

  task automatic do_reset(input int unsigned p);
    @(negedge clk);
    rst_n = 1'b0;
    start_i = 1'b0;
    period_i = PW'(p);
    per_cur = p;
    repeat (3) @(negedge clk);
    chk(pos_o == '0, "R1 reset pos", pos_o, 0);
    chk(pcell_o == 1'b1, "R1 reset index", pcell_o, 1);
    chk(ready_o == 1'b0, "R1 reset ready", ready_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pos_o == '0 && pcell_o && !ready_o, "R1 after release", pos_o, 0);
  endtask

  task automatic free_run(input int unsigned n);
    for (int i = 0; i < n; i++) begin
      period_i = PW'($urandom_range(1, 255));   // R3: must be ignored
      if (i % 5 == 0) target_i = WB'($urandom_range(0, TW - 1));
      #1;
      check_now();
      chk(ready_o == 1'b0, "R8 no pulse unarmed", ready_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic arm_wait(input int unsigned tgt, input bit replace, input int unsigned tgt2);
    int unsigned n_a, n_r, fin, n;
    start_i  = 1'b1;
    target_i = WB'(tgt);
    @(negedge clk);
    if (replace) begin
      target_i = WB'(tgt2);
      @(negedge clk);
      tgt = tgt2;
    end
    start_i = 1'b0;
    n_a = cyc - 1;
    n_r = ready_edge(n_a, tgt, per_cur);
    fin = n_r + 2;
    n = cyc - 1;
    while (n <= fin) begin
      #1;
      check_now();
      if (replace) chk(ready_o == (n == n_r), "R8 replaced target pulse", ready_o, (n == n_r));
      else         chk(ready_o == (n == n_r), "R7 start ready pulse", ready_o, (n == n_r));
      @(negedge clk);
      n = cyc - 1;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int unsigned p, t;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start_i = 1'b0;
    period_i = PW'(1);
    target_i = '0;
    per_cur = 1;
    for (int run = 0; run < 6; run++) begin
      p = (run < 4) ? run + 1 : $urandom_range(1, 4);
      do_reset(p);
      free_run(p == 1 ? 2100 : 500);
      case (run)
        0: t = exp_pos(cyc, p);            // R7: full revolution case
        1: t = 0;
        2: t = TW - 1;
        3: t = (exp_pos(cyc, p) + 1) % TW;
        default: t = $urandom_range(0, TW - 1);
      endcase
      arm_wait(t, 1'b0, 0);
      arm_wait($urandom_range(0, TW - 1), 1'b1, $urandom_range(0, TW - 1));
    end
    summary();
  end
endmodule